// File: doc/BRIEF.md
# Keyed Nonvolatile Memory Program/Erase Controller

This block is the register front end that software uses to start program and erase operations on an on-chip nonvolatile array. A bus master writes four registers: control, key, target address and write data. The control register also has two alias addresses. One sets the bits written as 1 and the other clears them, so single fields can change without a read-modify-write. An operation is launched by writing the start bit. That write only has effect when writes are enabled, no operation is in flight, and it follows directly after a three-word unlock sequence on the key register. This keeps a stray store from altering the array.

When an operation launches, the block sends a single-cycle start pulse to the array backend, together with the operation code, the aligned address and the data word. The start bit then reads back as 1 until the backend reports completion. Error flags returned with the completion stay latched. Software can clear them only by running the no-operation command to completion under a valid unlock.

Erase covers pages of `PAGE_BYTES` bytes (16 KB by default; a bank holds 64 such pages).

Top module: `nvm_keyctl`

## Requirements
- R1: After reset, the control, address and data registers read 0 and `be_start_o` is low.
- R2: Writes to the key register at offset 0x10 unlock the block only as the exact sequence 0x00000000, 0xAA996655, 0x556699AA. Any key write that does not match the next expected word returns the tracker to its initial state, and that includes a key write made while unlocked. The key register always reads 0.
- R3: A start request is a write with bit 15 = 1 to the control register (0x00) or to its set alias (0x08). It launches when write-enable (bit 14) is 1, the block is unlocked and bit 15 is 0. A launch gives exactly one cycle of `be_start_o`, and bit 15 reads 1 from the next cycle.
- R4: A start request made with write-enable at 0 or while locked does nothing. Any write to the control register or its aliases uses up the unlock.
- R5: A start request while bit 15 is 1 does not launch, and it sets the write-error flag (bit 13).
- R6: The clear alias (0x04) clears the written 1 bits of op and write-enable. The set alias (0x08) sets them. A plain write replaces both. A write that carries a start request leaves op (bits 3:0) and write-enable unchanged.
- R7: Bit 15 clears in the cycle after `be_done_i` is seen. Software cannot clear it.
- R8: On completion of a command other than NOP, `be_wrerr_i` and `be_lverr_i` are ORed into bits 13 and 12. Software writes never change those bits.
- R9: Completion of an unlocked NOP (op 0) clears bits 13 and 12.
- R10: While bit 15 is 1, writes to the address (0x20), data (0x30) and op field are ignored.
- R11: For page erase (op 4) the backend address is rounded down to a `PAGE_BYTES` boundary. For program (op 1) and other codes it is rounded down to 4 bytes. The data register is passed on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| be_start_o | output | 1 | One-cycle launch pulse to the array backend |
| be_op_o | output | 4 | Operation code of the launched command |
| be_addr_o | output | ADDR_W | Aligned target address |
| be_data_o | output | 32 | Word to program |
| be_done_i | input | 1 | Backend completion pulse |
| be_wrerr_i | input | 1 | Write error, valid with `be_done_i` |
| be_lverr_i | input | 1 | Low-voltage error, valid with `be_done_i` |

## Verification
All 27 three-write key sequences built from the three key words are tried. Only the exact ordered sequence may launch, which tells a proper order tracker apart from one that only counts matching words. Sequences that are interrupted, overlong, or followed by a stray control write separate a correct restart-and-consume rule from a sticky unlock. A sweep of unaligned addresses over alternating erase and program commands shows whether page alignment is applied by op code. Error injection, followed by software writes and by locked and unlocked NOP runs, shows that the flags are sticky and are cleared only by an unlocked NOP that completes.

// File: rtl/nvm_keyctl_pkg.sv
package nvm_keyctl_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned OP_W  = 4;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_CTRL_CLR = 8'h04;
  localparam logic [7:0] OFS_CTRL_SET = 8'h08;
  localparam logic [7:0] OFS_KEY      = 8'h10;
  localparam logic [7:0] OFS_ADDR     = 8'h20;
  localparam logic [7:0] OFS_DATA     = 8'h30;

  localparam int unsigned BIT_START = 15;
  localparam int unsigned BIT_WREN  = 14;
  localparam int unsigned BIT_WRERR = 13;
  localparam int unsigned BIT_LVERR = 12;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_PROG  = 4'd1;
  localparam logic [OP_W-1:0] OP_ERASE = 4'd4;

  localparam logic [BUS_W-1:0] KEY_W0 = 32'h0000_0000;
  localparam logic [BUS_W-1:0] KEY_W1 = 32'hAA99_6655;
  localparam logic [BUS_W-1:0] KEY_W2 = 32'h5566_99AA;

  typedef enum logic [1:0] {KS_IDLE, KS_ONE, KS_TWO, KS_OPEN} key_state_e;
  typedef enum logic [1:0] {WM_PLAIN, WM_CLR, WM_SET} wmode_e;
endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_keyctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [BUS_W-1:0] key_val_i,
  input  logic             consume_i,
  output logic             unlocked_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      unique case (state_q)
        KS_IDLE: state_d = (key_val_i == KEY_W0) ? KS_ONE  : KS_IDLE;
        KS_ONE:  state_d = (key_val_i == KEY_W1) ? KS_TWO  : KS_IDLE;
        KS_TWO:  state_d = (key_val_i == KEY_W2) ? KS_OPEN : KS_IDLE;
        default: state_d = KS_IDLE;
      endcase
    end else if (consume_i) begin
      state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == KS_OPEN);
endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_keyctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  wmode_e           wmode_i,
  input  logic             wstart_i,
  input  logic             wwren_i,
  input  logic [OP_W-1:0]  wop_i,
  input  logic             unlocked_i,
  input  logic             done_i,
  input  logic             be_wrerr_i,
  input  logic             be_lverr_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic             busy_o,
  output logic             launch_o,
  output logic [OP_W-1:0]  op_o
);
  logic            busy_q, wren_q, wrerr_q, lverr_q;
  logic [OP_W-1:0] op_q;
  logic            req, req_w, m_wren;
  logic [OP_W-1:0] m_op;

  always_comb begin
    unique case (wmode_i)
      WM_CLR: begin
        req    = 1'b0;
        m_wren = wren_q & ~wwren_i;
        m_op   = op_q & ~wop_i;
      end
      WM_SET: begin
        req    = wstart_i;
        m_wren = wren_q | wwren_i;
        m_op   = op_q | wop_i;
      end
      default: begin
        req    = wstart_i;
        m_wren = wwren_i;
        m_op   = wop_i;
      end
    endcase
  end

  assign req_w    = wr_i & req;
  assign launch_o = req_w & wren_q & unlocked_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wren_q  <= 1'b0;
      wrerr_q <= 1'b0;
      lverr_q <= 1'b0;
      op_q    <= OP_NOP;
    end else begin
      // fields move only on writes without a start request
      if (wr_i && !req) begin
        wren_q <= m_wren;
        if (!busy_q) op_q <= m_op;
      end
      if (launch_o) begin
        busy_q <= 1'b1;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
        if (op_q == OP_NOP) begin
          wrerr_q <= 1'b0;
          lverr_q <= 1'b0;
        end else begin
          wrerr_q <= wrerr_q | be_wrerr_i;
          lverr_q <= lverr_q | be_lverr_i;
        end
      end
      if (req_w && busy_q) wrerr_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_o            = '0;
    ctrl_o[OP_W-1:0]  = op_q;
    ctrl_o[BIT_START] = busy_q;
    ctrl_o[BIT_WREN]  = wren_q;
    ctrl_o[BIT_WRERR] = wrerr_q;
    ctrl_o[BIT_LVERR] = lverr_q;
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
endmodule

// File: rtl/nvm_cmd_latch.sv
module nvm_cmd_latch
  import nvm_keyctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic              data_we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              launch_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BUS_W-1:0]  data_o,
  output logic              be_start_o,
  output logic [OP_W-1:0]   be_op_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [BUS_W-1:0]  be_data_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] addr_q, aligned;
  logic [BUS_W-1:0]  data_q;

  assign aligned = addr_q & ((op_i == OP_ERASE) ? PAGE_MASK : WORD_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      data_q     <= '0;
      be_start_o <= 1'b0;
      be_op_o    <= OP_NOP;
      be_addr_o  <= '0;
      be_data_o  <= '0;
    end else begin
      if (addr_we_i && !busy_i) addr_q <= wdata_i[ADDR_W-1:0];
      if (data_we_i && !busy_i) data_q <= wdata_i;
      be_start_o <= launch_i;
      if (launch_i) begin
        be_op_o   <= op_i;
        be_addr_o <= aligned;
        be_data_o <= data_q;
      end
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/nvm_keyctl.sv
module nvm_keyctl
  import nvm_keyctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              be_start_o,
  output logic [3:0]        be_op_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [31:0]       be_data_o,
  input  logic              be_done_i,
  input  logic              be_wrerr_i,
  input  logic              be_lverr_i
);
  logic              sel_ctrl, key_we, addr_we, data_we, ctrl_we;
  wmode_e            wmode;
  logic              unlocked, busy, launch;
  logic [BUS_W-1:0]  ctrl_q, data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OP_W-1:0]   op_q;

  always_comb begin
    sel_ctrl = 1'b1;
    wmode    = WM_PLAIN;
    unique case (reg_addr_i)
      OFS_CTRL:     wmode = WM_PLAIN;
      OFS_CTRL_CLR: wmode = WM_CLR;
      OFS_CTRL_SET: wmode = WM_SET;
      default:      sel_ctrl = 1'b0;
    endcase
  end

  assign ctrl_we = reg_we_i & sel_ctrl;
  assign key_we  = reg_we_i & (reg_addr_i == OFS_KEY);
  assign addr_we = reg_we_i & (reg_addr_i == OFS_ADDR);
  assign data_we = reg_we_i & (reg_addr_i == OFS_DATA);

  nvm_key_seq i_key_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (key_we),
    .key_val_i  (reg_wdata_i),
    .consume_i  (ctrl_we),
    .unlocked_o (unlocked)
  );

  nvm_ctrl_reg i_ctrl_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_we),
    .wmode_i    (wmode),
    .wstart_i   (reg_wdata_i[BIT_START]),
    .wwren_i    (reg_wdata_i[BIT_WREN]),
    .wop_i      (reg_wdata_i[OP_W-1:0]),
    .unlocked_i (unlocked),
    .done_i     (be_done_i),
    .be_wrerr_i (be_wrerr_i),
    .be_lverr_i (be_lverr_i),
    .ctrl_o     (ctrl_q),
    .busy_o     (busy),
    .launch_o   (launch),
    .op_o       (op_q)
  );

  nvm_cmd_latch #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_cmd_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_we_i  (addr_we),
    .data_we_i  (data_we),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .launch_i   (launch),
    .op_i       (op_q),
    .addr_o     (addr_q),
    .data_o     (data_q),
    .be_start_o (be_start_o),
    .be_op_o    (be_op_o),
    .be_addr_o  (be_addr_o),
    .be_data_o  (be_data_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL, OFS_CTRL_CLR, OFS_CTRL_SET: reg_rdata_o = ctrl_q;
      OFS_ADDR: reg_rdata_o = 32'(addr_q);
      OFS_DATA: reg_rdata_o = data_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nvm_keyctl_chk.sv
module nvm_keyctl_chk
  import nvm_keyctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BYTES = 16384
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              be_start_o,
  input logic              be_done_i,
  input logic [3:0]        be_op_o,
  input logic [ADDR_W-1:0] be_addr_o,
  input logic [31:0]       be_data_o,
  input logic              busy,
  input logic              unlocked,
  input logic [31:0]       ctrl_q
);
  localparam logic [ADDR_W-1:0] PAGE_LOW = ADDR_W'(PAGE_BYTES - 1);

  // R3: launch pulse lasts one cycle and marks the block busy
  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |=> !be_start_o);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |-> busy);
  // R4: a launch is always preceded by an unlock
  p_launch_unlocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(be_start_o) |-> $past(unlocked));
  // R7: busy holds until done, and done ends it
  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !be_done_i) |=> busy);
  p_done_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && be_done_i && !be_start_o) |=> !busy);
  // R8: error flags only move while an operation is active
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(ctrl_q[13:12]));
  // R10: backend command stays put during an operation
  p_cmd_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !be_start_o) |-> ($stable(be_addr_o) && $stable(be_data_o) && $stable(be_op_o)));
  // R11: erase addresses are page aligned
  p_erase_align_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_op_o == OP_ERASE) |-> ((be_addr_o & PAGE_LOW) == '0));
endmodule

bind nvm_keyctl nvm_keyctl_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .be_start_o (be_start_o),
  .be_done_i  (be_done_i),
  .be_op_o    (be_op_o),
  .be_addr_o  (be_addr_o),
  .be_data_o  (be_data_o),
  .busy       (busy),
  .unlocked   (unlocked),
  .ctrl_q     (ctrl_q)
);

// File: tb/test_nvm_keyctl.sv
module test_nvm_keyctl;
  localparam logic [7:0] A_CTRL = 8'h00, A_CLR = 8'h04, A_SET = 8'h08;
  localparam logic [7:0] A_KEY = 8'h10, A_ADR = 8'h20, A_DAT = 8'h30;
  localparam logic [31:0] K0 = 32'h0000_0000, K1 = 32'hAA99_6655, K2 = 32'h5566_99AA;
  localparam logic [31:0] PAGE = 32'h0000_4000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0, rdata;
  logic        be_start, be_done = 1'b0, be_wrerr = 1'b0, be_lverr = 1'b0;
  logic [3:0]  be_op;
  logic [31:0] be_addr, be_data;

  nvm_keyctl i_nvm_keyctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .be_start_o(be_start),
    .be_op_o(be_op), .be_addr_o(be_addr), .be_data_o(be_data),
    .be_done_i(be_done), .be_wrerr_i(be_wrerr), .be_lverr_i(be_lverr)
  );

  int total = 0, bad = 0, n_starts = 0, lat = 4, cnt = 0;
  bit finished = 1'b0;
  logic inj_wr = 1'b0, inj_lv = 1'b0;
  logic [3:0] cap_op = '0;
  logic [31:0] cap_addr = '0, cap_data = '0;

  // array backend model
  always @(posedge clk) begin
    be_done  <= 1'b0;
    be_wrerr <= 1'b0;
    be_lverr <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        be_done  <= 1'b1;
        be_wrerr <= inj_wr;
        be_lverr <= inj_lv;
      end
    end
    if (be_start) begin
      cnt      <= lat;
      n_starts <= n_starts + 1;
      cap_op   <= be_op;
      cap_addr <= be_addr;
      cap_data <= be_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic unlock();
    wr(A_KEY, K0); wr(A_KEY, K1); wr(A_KEY, K2);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(A_CTRL, v);
      if (!v[15]) break;
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
    wr(A_ADR, a); wr(A_DAT, d); wr(A_CTRL, 32'h4000 | 32'(op));
    unlock(); wr(A_CTRL, 32'h8000); wait_idle();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    report();
  end

  initial begin
    logic [31:0] v, v2, a, e;
    int s0;
    logic [31:0] kv [3];
    kv[0] = K0; kv[1] = K1; kv[2] = K2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(A_ADR, v);  chk(v == 0, "R1 addr", v, 0);
    rd(A_DAT, v);  chk(v == 0, "R1 data", v, 0);
    chk(be_start == 0, "R1 start", 32'(be_start), 0);

    // R12-style map: address/data readback, key reads 0 (R2)
    wr(A_ADR, 32'h1234_5677); wr(A_DAT, 32'hDEAD_BEEF); wr(A_KEY, 32'h55);
    rd(A_ADR, v); chk(v == 32'h1234_5677, "R11 addr readback", v, 32'h1234_5677);
    rd(A_DAT, v); chk(v == 32'hDEAD_BEEF, "R11 data readback", v, 32'hDEAD_BEEF);
    rd(A_KEY, v); chk(v == 0, "R2 key reads zero", v, 0);

    // R6 aliases
    wr(A_CTRL, 32'h4001); rd(A_CTRL, v); chk(v == 32'h4001, "R6 plain", v, 32'h4001);
    wr(A_SET, 32'h0004);  rd(A_CLR, v);  chk(v == 32'h4005, "R6 set alias", v, 32'h4005);
    wr(A_CLR, 32'h4001);  rd(A_SET, v);  chk(v == 32'h0004, "R6 clr alias", v, 32'h0004);
    wr(A_SET, 32'h4000);  rd(A_CTRL, v); chk(v == 32'h4004, "R6 set wren", v, 32'h4004);
    wr(A_CTRL, 32'h4001);
    s0 = n_starts;
    wr(A_CTRL, 32'h8000); wait_idle(); rd(A_CTRL, v);
    chk(v == 32'h4001, "R6 start write keeps fields", v, 32'h4001);
    chk(n_starts == s0, "R4 locked start ignored", 32'(n_starts - s0), 0);

    // R4 wren low
    wr(A_CTRL, 32'h0001); unlock(); s0 = n_starts;
    wr(A_CTRL, 32'h8000); wait_idle(); rd(A_CTRL, v);
    chk(n_starts == s0 && v == 32'h0001, "R4 wren low", v, 32'h0001);

    // R4 consume by control write
    wr(A_CTRL, 32'h4001); unlock(); wr(A_SET, 32'h0); s0 = n_starts;
    wr(A_CTRL, 32'h8000); wait_idle();
    chk(n_starts == s0, "R4 unlock consumed", 32'(n_starts - s0), 0);

    // R2 key write while unlocked drops unlock
    unlock(); wr(A_KEY, K0); s0 = n_starts;
    wr(A_CTRL, 32'h8000); wait_idle();
    chk(n_starts == s0, "R2 fourth key relocks", 32'(n_starts - s0), 0);

    // R2 sweep of all 27 key sequences
    for (int i = 0; i < 27; i++) begin
      bit exp_go;
      exp_go = (i == 0 * 9 + 1 * 3 + 2);
      wr(A_CTRL, 32'h4000);
      wr(A_KEY, kv[i / 9]); wr(A_KEY, kv[(i / 3) % 3]); wr(A_KEY, kv[i % 3]);
      s0 = n_starts;
      wr(A_CTRL, 32'h8000); wait_idle();
      chk((n_starts - s0) == int'(exp_go), "R2 key sequence", 32'(n_starts - s0), 32'(exp_go));
    end

    // R2 restart after a broken sequence
    wr(A_KEY, 32'h1); wr(A_KEY, K1); unlock(); s0 = n_starts;
    wr(A_CTRL, 32'h8000); wait_idle();
    chk(n_starts == s0 + 1, "R2 restart after break", 32'(n_starts - s0), 1);

    // R3/R7 launch timing and busy
    lat = 10;
    wr(A_ADR, 32'h100); wr(A_DAT, 32'h5A5A_0001); wr(A_CTRL, 32'h4001); unlock();
    wr(A_CTRL, 32'h8000);
    chk(be_start == 1'b1, "R3 start pulse", 32'(be_start), 1);
    rd(A_CTRL, v);
    chk(be_start == 1'b0, "R3 pulse one cycle", 32'(be_start), 0);
    chk(v == 32'hC001, "R3 busy readback", v, 32'hC001);
    wr(A_CLR, 32'h8000); rd(A_CTRL, v);
    chk(v[15] == 1'b1, "R7 software cannot clear busy", v, 32'hC001);
    wait_idle(); rd(A_CTRL, v);
    chk(v == 32'h4001, "R7 done clears busy", v, 32'h4001);

    // R10 writes ignored while busy
    lat = 30;
    wr(A_ADR, 32'h200); wr(A_DAT, 32'h1111_2222); wr(A_CTRL, 32'h4001); unlock();
    wr(A_CTRL, 32'h8000);
    wr(A_ADR, 32'h999); wr(A_DAT, 32'h3333_4444); wr(A_CTRL, 32'h4004);
    rd(A_ADR, v); chk(v == 32'h200, "R10 addr held", v, 32'h200);
    rd(A_DAT, v); chk(v == 32'h1111_2222, "R10 data held", v, 32'h1111_2222);
    rd(A_CTRL, v); chk(v[3:0] == 4'h1, "R10 op held", v, 32'hC001);
    wait_idle(); rd(A_CTRL, v); chk(v == 32'h4001, "R10 op after done", v, 32'h4001);

    // R5 start while busy
    s0 = n_starts;
    unlock(); wr(A_CTRL, 32'h8000); unlock(); wr(A_CTRL, 32'h8000);
    rd(A_CTRL, v); chk(v == 32'hE001, "R5 wrerr on busy start", v, 32'hE001);
    wait_idle();
    chk(n_starts == s0 + 1, "R5 no second launch", 32'(n_starts - s0), 1);
    rd(A_CTRL, v); chk(v == 32'h6001, "R5 flag kept", v, 32'h6001);
    lat = 4;
    run_op(4'h0, 32'h0, 32'h0); rd(A_CTRL, v);
    chk(v == 32'h4000, "R9 nop clears", v, 32'h4000);

    // R8 error latching
    inj_wr = 1'b1; run_op(4'h1, 32'h40, 32'h0); inj_wr = 1'b0;
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h2000, "R8 wrerr latched", v & 32'h3000, 32'h2000);
    wr(A_CTRL, 32'h4001); wr(A_CLR, 32'h3000);
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h2000, "R8 sw cannot clear", v & 32'h3000, 32'h2000);
    inj_lv = 1'b1; run_op(4'h4, 32'h8000, 32'h0); inj_lv = 1'b0;
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h3000, "R8 lverr ored", v & 32'h3000, 32'h3000);
    run_op(4'h1, 32'h44, 32'h0);
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h3000, "R8 clean op keeps", v & 32'h3000, 32'h3000);
    wr(A_CTRL, 32'h4000); wr(A_CTRL, 32'h8000); wait_idle();
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h3000, "R9 locked nop no clear", v & 32'h3000, 32'h3000);
    run_op(4'h0, 32'h0, 32'h0);
    rd(A_CTRL, v); chk((v & 32'h3000) == 32'h0, "R9 unlocked nop clears", v & 32'h3000, 0);

    // R11 alignment sweep
    for (int i = 0; i < 12; i++) begin
      logic [3:0] op;
      op = (i % 2 == 0) ? 4'h4 : 4'h1;
      a  = 32'(i) * 32'h0001_2F35 + 32'h3;
      e  = (op == 4'h4) ? (a & ~(PAGE - 1)) : (a & ~32'h3);
      v2 = 32'hC0DE_0000 + 32'(i);
      run_op(op, a, v2);
      chk(cap_addr == e, "R11 aligned addr", cap_addr, e);
      chk(cap_op == op && cap_data == v2, "R3 op and data passed", cap_data, v2);
    end

    report();
  end
endmodule